// File: doc/BRIEF.md
# Digital Wiper Register File with Non-Volatile Shadow

This block holds the register state behind a 128-position digitally controlled resistor wiper. It keeps a live 7-bit wiper code, a retained start-up code, a retained mode byte and a live access-control byte. The retained registers are ordinary flops, and a countdown stands in for the programming time of a real memory cell. A serial-bus slave in front of the block passes each received data byte as a one-cycle write on `wrEn`. It pulses `stopStb` when the bus STOP closes the transaction, and it reads any register through the combinational `rdAddr`/`rdData` port.

Address 0 reaches two registers. When the routing bit in the access byte is clear, a write there moves the live wiper at once and also stages a new start-up code. The next STOP starts a timed program cycle, and the staged value lands in the retained register only when that cycle ends. The access byte shows a busy flag during the program cycle. While the flag is set, every write is refused and flagged for one cycle. The block also runs the power-up sequence. While the supply is not good it holds the wiper at mid-scale. When the supply becomes good it reloads the wiper from the retained start-up code. It then keeps `powerBusy` high for a fixed settle time, during which the bus slave ignores START.

Top module: `wiper_reg_bank`

## Requirements
- R1: After reset, `wiperCode` is 40h and the start-up code is 40h. Address 2 reads 40h, address 1 reads 00h, `powerBusy` is 1, and `shutdownOut`, `dividerMode` and `precisionOff` are 0.
- R2: While `supplyGood` is low, `wiperCode` is held at 40h and `powerBusy` stays 1. On the first edge that samples `supplyGood` high, the wiper loads the start-up code. `powerBusy` falls exactly RECALL_CYC+1 edges after that first edge, counting the first edge itself.
- R3: When the routing bit (address 2 bit 7) is 1, address 0 reads and writes only the live wiper. When it is 0, address 0 reads the start-up code, and a write there updates the wiper on the next edge and stages the value for the start-up code. The start-up code itself does not change until the program cycle completes.
- R4: A `stopStb` with a staged write starts a program cycle. During the cycle address 2 bit 5 reads 1 for exactly NV_PROG_CYC cycles, and the target register takes the value when the bit clears. If several writes are staged before one STOP, the last one wins. A `stopStb` with nothing staged changes nothing.
- R5: A write that arrives while the program bit is 1, or while `powerBusy` is 1, changes no register. `wrRefused` is 1 in the cycle after that write.
- R6: Address 2 holds the routing bit in bit 7, the run bit in bit 6 and the program bit in bit 5; the program bit is read-only. Bits 4:0 read 0. `shutdownOut` is the inverse of the run bit.
- R7: Address 1 bit 7 drives `dividerMode` and bit 6 drives `precisionOff`. Bits 5:0 read 0. A write to address 1 is staged and programmed like the start-up code, so both outputs change only when a program cycle completes.
- R8: The wiper and the start-up code keep only data bits 6:0. A written FFh reads back as 7Fh.
- R9: When `supplyGood` falls, the wiper returns to 40h and address 2 returns to 40h. A staged or in-flight program is dropped. The retained registers keep their values, and the next recall loads the retained start-up code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (first power-on, factory state) |
| supplyGood | input | 1 | Supply high enough for retained memory |
| wrEn | input | 1 | One-cycle register write request |
| wrAddr | input | 2 | Write address |
| wrData | input | 8 | Write data |
| stopStb | input | 1 | Bus STOP seen, commit staged retained write |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data (combinational) |
| wiperCode | output | 7 | Live wiper position |
| shutdownOut | output | 1 | Wiper in shutdown |
| dividerMode | output | 1 | 1 = three-terminal divider, 0 = rheostat |
| precisionOff | output | 1 | Precision matching disabled |
| powerBusy | output | 1 | Power-up recall not finished; bus ignores START |
| wrRefused | output | 1 | One-cycle pulse for a refused write |

## Verification
A wrong routing decision appears at once: `wiperCode` moves, or fails to move, on the edge after the write, and the address 0 read shows the wrong register in the same cycle. A wrong program counter or a lost staging flag shows up only at the end of the program window. There the program bit clears early or late, or the retained value reads back unchanged, so the bench samples both the last busy cycle and the first idle one. A recall that loads the wrong source is visible only after a supply drop, when the wiper must come back to a value that differs from the mid-scale default.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [1:0] {
    PWR_WAIT   = 2'd0,
    PWR_SETTLE = 2'd1,
    PWR_READY  = 2'd2
  } pwrState_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic forceDefaults;  // supply low: mid-scale wiper, access byte defaults
    logic recall;         // load wiper from retained start-up code
    logic wrWiper;        // write live wiper
    logic wrAccess;       // write access byte
    logic stageNv;        // capture retained write for later program
    logic stageIsMode;    // staged target is the mode byte
    logic commitNv;       // program cycle finished, update retained reg
  } wipStrobes_t;

  localparam logic [1:0] ADDR_CODE   = 2'd0;
  localparam logic [1:0] ADDR_MODE   = 2'd1;
  localparam logic [1:0] ADDR_ACCESS = 2'd2;

endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int RECALL_CYC  = 200000,
  parameter int NV_PROG_CYC = 2400000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyGood,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic        stopStb,
  input  logic        volSel,
  output wipStrobes_t strobes,
  output logic        powerBusy,
  output logic        wipFlag,
  output logic        wrRefused
);

  localparam int RC_W = $clog2(RECALL_CYC + 1);
  localparam int PC_W = $clog2(NV_PROG_CYC + 1);
  localparam logic [RC_W-1:0] RECALL_LAST = RC_W'(RECALL_CYC - 1);
  localparam logic [PC_W-1:0] PROG_LAST   = PC_W'(NV_PROG_CYC - 1);

  pwrState_t       pwrState;
  logic [RC_W-1:0] recallCnt;
  logic [PC_W-1:0] progCnt;
  logic            nvPend;
  logic            wipQ;
  logic            refusedQ;

  logic accept;
  logic refuse;
  logic startProg;

  always_comb begin
    accept    = wrEn && supplyGood && (pwrState == PWR_READY) && !wipQ;
    refuse    = wrEn && !accept;
    startProg = stopStb && nvPend && !wipQ && supplyGood && (pwrState == PWR_READY);

    strobes               = '0;
    strobes.forceDefaults = !supplyGood;
    strobes.recall        = supplyGood && (pwrState == PWR_WAIT);
    strobes.wrWiper       = accept && (wrAddr == ADDR_CODE);
    strobes.wrAccess      = accept && (wrAddr == ADDR_ACCESS);
    strobes.stageNv       = accept && (((wrAddr == ADDR_CODE) && !volSel) ||
                                       (wrAddr == ADDR_MODE));
    strobes.stageIsMode   = (wrAddr == ADDR_MODE);
    strobes.commitNv      = wipQ && supplyGood && (progCnt == PROG_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrState  <= PWR_WAIT;
      recallCnt <= '0;
      progCnt   <= '0;
      nvPend    <= 1'b0;
      wipQ      <= 1'b0;
      refusedQ  <= 1'b0;
    end else begin
      refusedQ <= refuse;
      if (!supplyGood) begin
        pwrState  <= PWR_WAIT;
        recallCnt <= '0;
        progCnt   <= '0;
        nvPend    <= 1'b0;
        wipQ      <= 1'b0;
      end else begin
        case (pwrState)
          PWR_WAIT: begin
            pwrState  <= PWR_SETTLE;
            recallCnt <= '0;
          end
          PWR_SETTLE: begin
            if (recallCnt == RECALL_LAST) pwrState <= PWR_READY;
            else recallCnt <= recallCnt + 1'b1;
          end
          default: pwrState <= PWR_READY;
        endcase

        if (strobes.stageNv) nvPend <= 1'b1;
        else if (startProg)  nvPend <= 1'b0;

        if (startProg) begin
          wipQ    <= 1'b1;
          progCnt <= '0;
        end else if (strobes.commitNv) begin
          wipQ <= 1'b0;
        end else if (wipQ) begin
          progCnt <= progCnt + 1'b1;
        end
      end
    end
  end

  assign powerBusy = (pwrState != PWR_READY);
  assign wipFlag   = wipQ;
  assign wrRefused = refusedQ;

endmodule

// File: rtl/wiper_dp.sv
module wiper_dp
  import wiper_pkg::*;
#(
  parameter int              CODE_W      = 7,
  parameter int              DATA_W      = 8,
  parameter logic [CODE_W-1:0] FORCE_CODE  = 7'h40,
  parameter logic [CODE_W-1:0] IVR_DEFAULT = 7'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  wipStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wipFlag,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [CODE_W-1:0] wiperCode,
  output logic              volSel,
  output logic              runBit,
  output logic              dividerMode,
  output logic              precisionOff
);

  localparam int PAD_W  = DATA_W - CODE_W;
  localparam int ACC_LO = DATA_W - 3;
  localparam int MSB    = DATA_W - 1;

  logic [CODE_W-1:0] wiperQ;
  logic [CODE_W-1:0] startCodeQ;
  logic              modeDivQ;
  logic              modePrecOffQ;
  logic              volQ;
  logic              runQ;
  logic [DATA_W-1:0] stageData;
  logic              stageMode;

  // live registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wiperQ <= FORCE_CODE;
      volQ   <= 1'b0;
      runQ   <= 1'b1;
    end else if (strobes.forceDefaults) begin
      wiperQ <= FORCE_CODE;
      volQ   <= 1'b0;
      runQ   <= 1'b1;
    end else begin
      if (strobes.recall)       wiperQ <= startCodeQ;
      else if (strobes.wrWiper) wiperQ <= wrData[CODE_W-1:0];
      if (strobes.wrAccess) begin
        volQ <= wrData[MSB];
        runQ <= wrData[MSB-1];
      end
    end
  end

  // staging and retained registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageData    <= '0;
      stageMode    <= 1'b0;
      startCodeQ   <= IVR_DEFAULT;
      modeDivQ     <= 1'b0;
      modePrecOffQ <= 1'b0;
    end else begin
      if (strobes.stageNv) begin
        stageData <= wrData;
        stageMode <= strobes.stageIsMode;
      end
      if (strobes.commitNv) begin
        if (stageMode) begin
          modeDivQ     <= stageData[MSB];
          modePrecOffQ <= stageData[MSB-1];
        end else begin
          startCodeQ <= stageData[CODE_W-1:0];
        end
      end
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_CODE:   rdData = volQ ? {{PAD_W{1'b0}}, wiperQ} : {{PAD_W{1'b0}}, startCodeQ};
      ADDR_MODE:   rdData = {modeDivQ, modePrecOffQ, {(DATA_W-2){1'b0}}};
      ADDR_ACCESS: rdData = {volQ, runQ, wipFlag, {ACC_LO{1'b0}}};
      default:     rdData = '0;
    endcase
  end

  assign wiperCode    = wiperQ;
  assign volSel       = volQ;
  assign runBit       = runQ;
  assign dividerMode  = modeDivQ;
  assign precisionOff = modePrecOffQ;

endmodule

// File: rtl/wiper_reg_bank.sv
module wiper_reg_bank
  import wiper_pkg::*;
#(
  parameter int                CODE_W      = 7,
  parameter int                DATA_W      = 8,
  parameter logic [CODE_W-1:0] FORCE_CODE  = 7'h40,
  parameter logic [CODE_W-1:0] IVR_DEFAULT = 7'h40,
  parameter int                RECALL_CYC  = 200000,
  parameter int                NV_PROG_CYC = 2400000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyGood,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stopStb,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [CODE_W-1:0] wiperCode,
  output logic              shutdownOut,
  output logic              dividerMode,
  output logic              precisionOff,
  output logic              powerBusy,
  output logic              wrRefused
);

  wipStrobes_t strobes;
  logic        volSel;
  logic        runBit;
  logic        wipFlag;

  wiper_ctrl #(
    .RECALL_CYC (RECALL_CYC),
    .NV_PROG_CYC(NV_PROG_CYC)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .supplyGood(supplyGood),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .stopStb   (stopStb),
    .volSel    (volSel),
    .strobes   (strobes),
    .powerBusy (powerBusy),
    .wipFlag   (wipFlag),
    .wrRefused (wrRefused)
  );

  wiper_dp #(
    .CODE_W     (CODE_W),
    .DATA_W     (DATA_W),
    .FORCE_CODE (FORCE_CODE),
    .IVR_DEFAULT(IVR_DEFAULT)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .wipFlag     (wipFlag),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .wiperCode   (wiperCode),
    .volSel      (volSel),
    .runBit      (runBit),
    .dividerMode (dividerMode),
    .precisionOff(precisionOff)
  );

  assign shutdownOut = !runBit;

endmodule

// File: rtl/wiper_reg_bank_chk.sv
module wiper_reg_bank_chk #(
  parameter int                CODE_W      = 7,
  parameter logic [CODE_W-1:0] FORCE_CODE  = 7'h40,
  parameter int                RECALL_CYC  = 200000,
  parameter int                NV_PROG_CYC = 2400000
) (
  input logic              clk,
  input logic              rstN,
  input logic              supplyGood,
  input logic              wrEn,
  input logic [CODE_W-1:0] wiperCode,
  input logic              dividerMode,
  input logic              precisionOff,
  input logic              powerBusy,
  input logic              wrRefused,
  input logic              wipFlag
);

  int unsigned busyRun;
  int unsigned wipRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyRun <= 0;
      wipRun  <= 0;
    end else begin
      busyRun <= (powerBusy && supplyGood) ? busyRun + 1 : 0;
      wipRun  <= wipFlag ? wipRun + 1 : 0;
    end
  end

  AST_SUPPLY_LOW_FORCES: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> (powerBusy && wiperCode == FORCE_CODE)); // R2

  AST_RECALL_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RECALL_CYC + 1); // R2

  AST_REFUSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    wrRefused |-> $past(wrEn)); // R5

  AST_WIP_FREEZES_WIPER: assert property (@(posedge clk) disable iff (!rstN)
    (wipFlag && $past(wipFlag) && supplyGood && $past(supplyGood)) |-> $stable(wiperCode)); // R5

  AST_PROG_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    wipRun <= NV_PROG_CYC); // R4

  AST_MODE_MOVES_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({dividerMode, precisionOff}) |-> $fell(wipFlag)); // R7

endmodule

bind wiper_reg_bank wiper_reg_bank_chk #(
  .CODE_W     (CODE_W),
  .FORCE_CODE (FORCE_CODE),
  .RECALL_CYC (RECALL_CYC),
  .NV_PROG_CYC(NV_PROG_CYC)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .supplyGood  (supplyGood),
  .wrEn        (wrEn),
  .wiperCode   (wiperCode),
  .dividerMode (dividerMode),
  .precisionOff(precisionOff),
  .powerBusy   (powerBusy),
  .wrRefused   (wrRefused),
  .wipFlag     (wipFlag)
);

// File: tb/wiper_reg_bank_tb_top.sv
`timescale 1ns/1ps
module wiper_reg_bank_tb_top;

  localparam int RC = 16;
  localparam int PC = 20;

  logic       clk = 1'b0;
  logic       rstN;
  logic       supplyGood;
  logic       wrEn;
  logic [1:0] wrAddr;
  logic [7:0] wrData;
  logic       stopStb;
  logic [1:0] rdAddr;
  logic [7:0] rdData;
  logic [6:0] wiperCode;
  logic       shutdownOut, dividerMode, precisionOff, powerBusy, wrRefused;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wiper_reg_bank #(.RECALL_CYC(RC), .NV_PROG_CYC(PC)) dut_i (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .stopStb(stopStb), .rdAddr(rdAddr),
    .rdData(rdData), .wiperCode(wiperCode), .shutdownOut(shutdownOut),
    .dividerMode(dividerMode), .precisionOff(precisionOff),
    .powerBusy(powerBusy), .wrRefused(wrRefused)
  );

  // scoreboard: sel 0..3 = read address, 4 wiper, 5 shutdown, 6 divider,
  // 7 precision-off, 8 powerBusy, 9 wrRefused
  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbQ[$];

  function automatic logic [7:0] observe(int sel);
    case (sel)
      0, 1, 2, 3: return rdData;
      4: return {1'b0, wiperCode};
      5: return {7'd0, shutdownOut};
      6: return {7'd0, dividerMode};
      7: return {7'd0, precisionOff};
      8: return {7'd0, powerBusy};
      default: return {7'd0, wrRefused};
    endcase
  endfunction

  always @(negedge clk) begin
    while (sbQ.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sbQ.pop_front();
      act = observe(it.sel);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic expectNow(int sel, logic [7:0] exp, string tag);
    item_t it;
    if (sel < 4) rdAddr = sel[1:0];
    it.sel = sel; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic check(int sel, logic [7:0] exp, string tag);
    @(posedge clk); #1;
    expectNow(sel, exp, tag);
  endtask

  task automatic directCmp(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, logic expRef, string tag);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
    expectNow(9, {7'd0, expRef}, tag);
  endtask

  task automatic stopt();
    @(posedge clk); #1;
    stopStb = 1'b1;
    @(posedge clk); #1;
    stopStb = 1'b0;
  endtask

  task automatic waitRecall(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk); #1;
      n++;
      if (!powerBusy) break;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rstN = 1'b0; supplyGood = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    stopStb = 1'b0; rdAddr = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    expectNow(4, 8'h40, "R1 wiper");
    expectNow(5, 8'h00, "R1 shutdown");
    expectNow(6, 8'h00, "R1 divider");
    expectNow(7, 8'h00, "R1 precOff");
    expectNow(8, 8'h01, "R1 busy");
    check(2, 8'h40, "R1 access byte");
    check(0, 8'h40, "R1 start code");
    check(1, 8'h00, "R1 mode byte");

    // R5 write during power-up refused
    wr(2'd2, 8'hC0, 1'b1, "R5 refused while busy");
    check(2, 8'h40, "R5 access unchanged");

    // R2 recall timing
    @(posedge clk); #1 supplyGood = 1'b1;
    waitRecall(n);
    directCmp(n, RC + 1, "R2 busy length");
    expectNow(4, 8'h40, "R2 wiper after recall");

    // R3 / R4 write via address 0 with routing bit clear
    wr(2'd0, 8'h25, 1'b0, "R3 accepted");
    expectNow(4, 8'h25, "R3 wiper updated at once");
    check(0, 8'h40, "R3 start code not yet programmed");
    stopt();
    check(2, 8'h60, "R4 program bit set");
    wr(2'd2, 8'hC0, 1'b1, "R5 refused during program");
    expectNow(4, 8'h25, "R5 wiper kept");
    repeat (PC - 5) @(posedge clk);
    check(2, 8'h60, "R4 program bit in last cycle");
    check(2, 8'h40, "R4 program bit cleared");
    check(0, 8'h25, "R4 start code programmed");

    // R3 routing bit set, R8 width
    wr(2'd2, 8'hC0, 1'b0, "R6 set routing");
    check(2, 8'hC0, "R6 routing bit read");
    wr(2'd0, 8'hFF, 1'b0, "R8 write");
    expectNow(4, 8'h7F, "R8 wiper 7 bits");
    check(0, 8'h7F, "R3 address 0 shows wiper");
    stopt();
    check(2, 8'hC0, "R4 stop with nothing staged");
    wr(2'd2, 8'h40, 1'b0, "R6 clear routing");
    check(0, 8'h25, "R3 start code kept");

    // R6 low bits ignored, shutdown
    wr(2'd2, 8'h3F, 1'b0, "R6 write");
    expectNow(5, 8'h01, "R6 shutdown on");
    check(2, 8'h00, "R6 low bits read 0");
    wr(2'd2, 8'h40, 1'b0, "R6 restore");
    expectNow(5, 8'h00, "R6 shutdown off");

    // R7 mode byte
    wr(2'd1, 8'hFF, 1'b0, "R7 write");
    stopt();
    check(6, 8'h00, "R7 divider waits for commit");
    repeat (PC + 2) @(posedge clk);
    check(6, 8'h01, "R7 divider set");
    expectNow(7, 8'h01, "R7 precOff set");
    check(1, 8'hC0, "R7 reserved bits 0");
    wr(2'd1, 8'h80, 1'b0, "R7 write 2");
    stopt();
    repeat (PC + 2) @(posedge clk);
    check(1, 8'h80, "R7 mode byte");
    expectNow(7, 8'h00, "R7 precOff cleared");

    // R4 last staged write wins
    wr(2'd0, 8'h11, 1'b0, "R4 stage a");
    wr(2'd0, 8'h22, 1'b0, "R4 stage b");
    expectNow(4, 8'h22, "R4 wiper follows");
    stopt();
    repeat (PC + 2) @(posedge clk);
    check(0, 8'h22, "R4 last write wins");

    // R9 supply drop aborts program
    wr(2'd2, 8'h00, 1'b0, "R9 shutdown before drop");
    wr(2'd0, 8'h33, 1'b0, "R9 stage");
    stopt();
    repeat (3) @(posedge clk);
    #1 supplyGood = 1'b0;
    check(4, 8'h40, "R9 wiper mid-scale");
    expectNow(8, 8'h01, "R9 busy");
    check(2, 8'h40, "R9 access defaults");
    expectNow(5, 8'h00, "R9 shutdown cleared");
    @(posedge clk); #1 supplyGood = 1'b1;
    waitRecall(n);
    directCmp(n, RC + 1, "R2 busy length again");
    expectNow(4, 8'h22, "R9 recall retained code");
    check(0, 8'h22, "R9 aborted program left code");
    check(1, 8'h80, "R9 mode retained");

    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule